// File: doc/BRIEF.md
# Serial Command and Status Interface

This block is a synchronous serial slave framed by an active-low chip select. During each frame a host shifts a 16-bit command word into the block, least significant bit first, and at the same time reads a 16-bit status word out on a data output that is driven only while the frame is open. The status word is a snapshot of the live status inputs taken at the moment chip select falls. The command word is decoded into control outputs: six switch enables, an open-load detection disable, a long-delay select, a run (not-inhibited) flag and a one-cycle status-clear strobe.

A command word takes effect only when the frame closes, and only when at least 16 serial clocks arrived. A shorter frame changes nothing. This lets a host read the temperature warning, which sits in bit 0 and is visible as soon as chip select falls, and then abort. If more than 16 clocks arrive, the last 16 bits received are applied. After the sixteenth clock the data output carries the bits received earlier in the frame, so several devices can be chained. The serial pins are resampled into a system clock that runs at least 8 times faster than the serial clock. Every output responds three system clocks after the pin edge that causes it.

Top module: `scs_iface`

## Requirements
- R1: `sdo_en` is low while chip select is high. It goes high three system clocks after chip select falls and low three system clocks after chip select rises.
- R2: The block samples `sdi` on falling edges of `sclk` inside a frame. The first bit received becomes command bit 0.
- R3: At chip select fall, `sdo` shows status bit 0. After that, `sdo` changes only on rising edges of `sclk`, and during the k-th serial clock (counting from 0) it shows status bit k for k below 16.
- R4: The command register changes only at chip select rise, and only if 16 or more `sclk` falling edges occurred in the frame. A frame with fewer clocks, including an early warning read, leaves every control output unchanged.
- R5: When a frame has more than 16 clocks, the block applies the last 16 bits received.
- R6: Command word fields are decoded as follows. Bits 1 to 6 drive `sw_en[0]` to `sw_en[5]` in order. Bit 13 drives `openload_off`, where 1 turns detection off. Bit 14 drives `long_delay`. Bit 15 drives `run_en`, where 0 means standby. Bits 7 to 12 are ignored.
- R7: If an applied word has bit 0 set, `stat_clr` is high for exactly one system clock, in the same cycle the new controls appear. Bit 0 is not stored.
- R8: The status word is laid out as follows. Bit 0 is `temp_warn`. Bits 1 to 6 are `out_stat[0]` to `out_stat[5]`. Bit 13 is `short_det`. Bit 14 is `inhibit`. Bit 15 is `supply_fail`. Bits 7 to 12 read 0. The inputs are sampled when chip select falls.
- R9: After reset, `run_en`, `long_delay` and `openload_off` are 1, `sw_en` is 0, `stat_clr` is 0 and `sdo_en` is 0.
- R10: From the seventeenth serial clock of a frame onward, `sdo` presents the bits received in that frame in arrival order, delayed by 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for the three-state data out |
| temp_warn | input | 1 | Live temperature warning |
| out_stat | input | 6 | Live per-output status |
| short_det | input | 1 | Live short detected flag |
| inhibit | input | 1 | Live standby flag |
| supply_fail | input | 1 | Live supply fail flag |
| stat_clr | output | 1 | One-cycle status clear strobe |
| sw_en | output | 6 | Switch enables |
| openload_off | output | 1 | Open-load detection disabled |
| long_delay | output | 1 | Long protection delay selected |
| run_en | output | 1 | Normal operation, low means standby |

## Verification
A wrong frame-state bit or clock count shows up at the control outputs on the first close of a frame. Controls either change after a short frame or fail to change after a full one, and this is visible three clocks after chip select rises. A corrupted shift register shows on `sdo` within one serial clock, either as a wrong status bit or, after the sixteenth clock, as a wrong echoed bit. A fault in the decode shows on the affected control output, or as a missing or doubled `stat_clr` pulse, in the cycle the word is applied. The bench checks each of these outputs on every system clock against its reference model.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NUM_SW = 6;
  localparam int unsigned SYNC_STAGES = 2;

  // command word bit positions
  localparam int unsigned CB_CLR   = 0;
  localparam int unsigned CB_SW0   = 1;
  localparam int unsigned CB_OLOFF = 13;
  localparam int unsigned CB_LDLY  = 14;
  localparam int unsigned CB_RUN   = 15;

  // status word bit positions
  localparam int unsigned SB_TW    = 0;
  localparam int unsigned SB_ST0   = 1;
  localparam int unsigned SB_SHORT = 13;
  localparam int unsigned SB_INH   = 14;
  localparam int unsigned SB_PSF   = 15;

  typedef struct packed {
    logic              run;
    logic              long_dly;
    logic              ol_off;
    logic [NUM_SW-1:0] sw;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{run: 1'b1, long_dly: 1'b1, ol_off: 1'b1, sw: '0};
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    logic [W-1:0] r_d;
    if (s == 0) begin : g_first
      assign r_d = d;
    end else begin : g_next
      assign r_d = g_stage[s-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= r_d;
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/scs_shifter.sv
module scs_shifter
  import scs_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_s,
  input  logic         sck_s,
  input  logic         sdi_s,
  input  logic [W-1:0] stat_word,
  output logic         sdo,
  output logic         sdo_en,
  output logic         apply,
  output logic [W-1:0] rx_word
);
  logic          cs_q, cs_d;
  logic          sck_q, sck_d;
  logic          in_frame_q, in_frame_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sr_q, sr_d;
  logic          do_q, do_d;
  logic          cs_fall, cs_rise, sck_fall, sck_rise;

  always_comb begin
    cs_fall  = cs_q & ~cs_s;
    cs_rise  = ~cs_q & cs_s;
    sck_fall = in_frame_q & ~cs_s & sck_q & ~sck_s;
    sck_rise = in_frame_q & ~cs_s & ~sck_q & sck_s;

    cs_d       = cs_s;
    sck_d      = sck_s;
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    sr_d       = sr_q;
    do_d       = do_q;

    if (cs_fall) begin
      in_frame_d = 1'b1;
      cnt_d      = '0;
      sr_d       = stat_word;
      do_d       = stat_word[0];
    end else if (cs_rise) begin
      in_frame_d = 1'b0;
    end else begin
      if (sck_fall) begin
        sr_d = {sdi_s, sr_q[W-1:1]};
        if (cnt_q != CW'(W)) cnt_d = cnt_q + 1'b1;
      end
      if (sck_rise) do_d = sr_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
      do_q       <= 1'b0;
    end else begin
      cs_q       <= cs_d;
      sck_q      <= sck_d;
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      sr_q       <= sr_d;
      do_q       <= do_d;
    end
  end

  assign apply   = cs_rise & in_frame_q & (cnt_q == CW'(W));
  assign rx_word = sr_q;
  assign sdo     = do_q;
  assign sdo_en  = in_frame_q;

  assert_hiz_after_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_en);
  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo == $past(stat_word[0])));
  assert_do_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !cs_fall) |=> $stable(sdo));
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
endmodule

// File: rtl/scs_ctrl_reg.sv
module scs_ctrl_reg
  import scs_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         apply,
  input  logic [W-1:0] rx_word,
  output ctrl_t        ctrl,
  output logic         stat_clr
);
  ctrl_t ctrl_q, ctrl_d, decoded;
  logic  clr_q, clr_d;

  always_comb begin
    decoded.run      = rx_word[CB_RUN];
    decoded.long_dly = rx_word[CB_LDLY];
    decoded.ol_off   = rx_word[CB_OLOFF];
    for (int i = 0; i < int'(NUM_SW); i++) decoded.sw[i] = rx_word[CB_SW0 + i];
    ctrl_d = apply ? decoded : ctrl_q;
    clr_d  = apply & rx_word[CB_CLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      clr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      clr_q  <= clr_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign stat_clr = clr_q;

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(ctrl));
  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> !stat_clr);
endmodule

// File: rtl/scs_iface.sv
module scs_iface
  import scs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  input  logic              temp_warn,
  input  logic [NUM_SW-1:0] out_stat,
  input  logic              short_det,
  input  logic              inhibit,
  input  logic              supply_fail,
  output logic              stat_clr,
  output logic [NUM_SW-1:0] sw_en,
  output logic              openload_off,
  output logic              long_delay,
  output logic              run_en
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rx_word;
  logic              apply;
  ctrl_t             ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  scs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    ({cs_n, sclk, sdi}),
    .q    (pins_s)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[SB_TW]    = temp_warn;
    for (int i = 0; i < int'(NUM_SW); i++) stat_word[SB_ST0 + i] = out_stat[i];
    stat_word[SB_SHORT] = short_det;
    stat_word[SB_INH]   = inhibit;
    stat_word[SB_PSF]   = supply_fail;
  end

  scs_shifter #(.W(WORD_W)) i_shifter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_s     (pins_s[2]),
    .sck_s    (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .stat_word(stat_word),
    .sdo      (sdo),
    .sdo_en   (sdo_en),
    .apply    (apply),
    .rx_word  (rx_word)
  );

  scs_ctrl_reg #(.W(WORD_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .apply   (apply),
    .rx_word (rx_word),
    .ctrl    (ctrl),
    .stat_clr(stat_clr)
  );

  assign sw_en        = ctrl.sw;
  assign openload_off = ctrl.ol_off;
  assign long_delay   = ctrl.long_dly;
  assign run_en       = ctrl.run;
endmodule

// File: tb/test_scs_iface.sv
module test_scs_iface;
  localparam int PER = 10;
  localparam int HALF_SCK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic temp_warn = 1'b0, short_det = 1'b0, inhibit = 1'b0, supply_fail = 1'b0;
  logic [5:0] out_stat = 6'b0;
  logic sdo, sdo_en, stat_clr, openload_off, long_delay, run_en;
  logic [5:0] sw_en;

  int n_chk = 0, n_err = 0, clr_cnt = 0;

  always #(PER/2) clk = ~clk;

  scs_iface i_scs_iface (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .temp_warn(temp_warn), .out_stat(out_stat),
    .short_det(short_det), .inhibit(inhibit), .supply_fail(supply_fail),
    .stat_clr(stat_clr), .sw_en(sw_en), .openload_off(openload_off),
    .long_delay(long_delay), .run_en(run_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated just after each clock edge
  logic [2:0] hist [4];
  bit   bitq [$];
  bit   m_in, m_do, m_clr, m_run, m_ldly, m_oloff;
  bit   [5:0] m_sw;
  int   m_falls;

  task automatic model_reset();
    for (int k = 0; k < 4; k++) hist[k] = 3'b100;
    m_in = 0; m_do = 0; m_clr = 0; m_falls = 0;
    m_run = 1; m_ldly = 1; m_oloff = 1; m_sw = '0;
    bitq.delete();
  endtask

  task automatic model_step();
    bit pc, cc, ps, cs_, d;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = {cs_n, sclk, sdi};
    pc = hist[3][2]; cc = hist[2][2];
    ps = hist[3][1]; cs_ = hist[2][1]; d = hist[2][0];
    m_clr = 0;
    if (pc && !cc) begin
      m_in = 1; m_falls = 0;
      bitq.delete();
      bitq.push_back(temp_warn);
      for (int k = 0; k < 6; k++) bitq.push_back(out_stat[k]);
      for (int k = 7; k < 13; k++) bitq.push_back(1'b0);
      bitq.push_back(short_det);
      bitq.push_back(inhibit);
      bitq.push_back(supply_fail);
      m_do = bitq[0];
    end else if (!pc && cc) begin
      if (m_in && m_falls >= 16) begin
        m_clr = bitq[0];
        for (int k = 0; k < 6; k++) m_sw[k] = bitq[1+k];
        m_oloff = bitq[13]; m_ldly = bitq[14]; m_run = bitq[15];
      end
      m_in = 0;
    end else if (m_in && !cc) begin
      if (ps && !cs_) begin
        bitq.push_back(d);
        void'(bitq.pop_front());
        m_falls++;
      end
      if (!ps && cs_) m_do = bitq[0];
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) model_reset();
    else model_step();
    if (stat_clr === 1'b1) clr_cnt++;
    chk("R1 sdo_en", 32'(sdo_en), 32'(m_in));
    if (m_in) chk("R3 sdo", 32'(sdo), 32'(m_do));
    chk("R6 controls", 32'({run_en, long_delay, openload_off, sw_en}),
        32'({m_run, m_ldly, m_oloff, m_sw}));
    chk("R7 stat_clr", 32'(stat_clr), 32'(m_clr));
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] data, input int n, output logic [63:0] seen);
    seen = '0;
    @(negedge clk); cs_n = 1'b0;
    wait_clks(HALF_SCK);
    for (int i = 0; i < n; i++) begin
      sdi = data[i]; sclk = 1'b1;
      wait_clks(HALF_SCK);
      seen[i] = sdo;
      sclk = 1'b0;
      wait_clks(HALF_SCK);
    end
    cs_n = 1'b1;
    wait_clks(HALF_SCK);
  endtask

  task automatic chk_ctrl(input string tag, input logic [5:0] sw, input logic ol, input logic ld, input logic rn);
    chk(tag, 32'({run_en, long_delay, openload_off, sw_en}), 32'({rn, ld, ol, sw}));
  endtask

  initial begin
    #(PER * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] seen;
    int clr_before;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(4);
    chk_ctrl("R9 reset controls", 6'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 reset sdo_en", 32'(sdo_en), 32'd0);
    chk("R9 reset stat_clr", 32'(stat_clr), 32'd0);

    // full frame with status snapshot
    out_stat = 6'b110010; short_det = 1'b1; supply_fail = 1'b1;
    frame(64'h805A, 16, seen);
    chk("R8 status word", 32'(seen[15:0]), 32'h0000A064);
    chk_ctrl("R2 R6 applied word", 6'b101101, 1'b0, 1'b0, 1'b1);
    chk("R1 sdo_en idle", 32'(sdo_en), 32'd0);

    // aborted frame
    frame(64'h0, 5, seen);
    chk_ctrl("R4 short frame ignored", 6'b101101, 1'b0, 1'b0, 1'b1);

    // early warning read
    temp_warn = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    wait_clks(6);
    chk("R3 early sdo_en", 32'(sdo_en), 32'd1);
    chk("R3 early warning bit", 32'(sdo), 32'd1);
    cs_n = 1'b1;
    wait_clks(6);
    chk("R1 closed after read", 32'(sdo_en), 32'd0);
    chk_ctrl("R4 warning read ignored", 6'b101101, 1'b0, 1'b0, 1'b1);

    // over-long frame
    frame(64'h6024F, 20, seen);
    chk_ctrl("R5 last 16 bits", 6'b010010, 1'b1, 1'b1, 1'b0);

    // status clear strobe
    clr_before = clr_cnt;
    frame(64'h8001, 16, seen);
    chk("R7 one clear pulse", 32'(clr_cnt - clr_before), 32'd1);
    chk_ctrl("R7 clear bit not stored", 6'b0, 1'b0, 1'b0, 1'b1);

    // daisy chain
    out_stat = 6'b001101; inhibit = 1'b1; temp_warn = 1'b0;
    frame({32'h0, 16'hA5C3, 16'h1234}, 32, seen);
    chk("R10 echoed bits", 32'(seen[31:16]), 32'h00001234);
    chk("R8 second status", 32'(seen[15:0]), 32'h0000E01A);
    chk_ctrl("R5 R6 chained word", 6'b100001, 1'b1, 1'b0, 1'b1);

    wait_clks(10);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule